// File: doc/BRIEF.md
# Link Frame Transmit Gearbox

This block turns one fixed 120-bit link frame per frame-clock period into a short burst of narrower words on the faster transceiver user clock, ready for a downstream serializer. The frame is put together inside the block from its fields: a 4-bit header code, two 2-bit control fields, an 80-bit data field and a 32-bit tail field. In the protected-frame variant the tail carries an externally computed check word. In the wide-payload variant it carries 32 extra user bits instead, so the frame has no error protection.

The word width is fixed at build time: 20-bit words give six words per frame, and 40-bit words give three. The most significant part of the frame leaves first, so the header is always at the top of word 0. A one-cycle frame strobe on the user clock loads a new frame and starts its burst. A word-valid flag marks every emitted word, and a frame-valid flag marks word 0. The frame clock and user clock come from one source, so the strobe arrives every 3 or 6 user cycles in normal operation. Scrambling, check-word computation, serialization, clocking and receive alignment are done elsewhere.

Top module: `link_tx_gearbox`

## Requirements
- R1: A synchronous reset sets the word output to all zeros and clears word-valid and frame-valid. They stay that way until the first frame strobe.
- R2: The frame is laid out, from bit 119 downward, as follows: header in 119:116, internal control in 115:114, data in 113:34, external control in 33:32 and tail in 31:0.
- R3: Bits 119:116 hold the parameter HDR_DATA when hdr_valid is 1 at the strobe, and the parameter HDR_IDLE when it is 0.
- R4: When WIDE_BUS is 1, the tail is extra_i and fec_i has no effect. When WIDE_BUS is 0, the tail is fec_i and extra_i has no effect.
- R5: The frame is sent as 120/WORD_W words. Word k carries frame bits 119-k·WORD_W down to 120-(k+1)·WORD_W. Word 0 is on the output in the cycle after the clock edge that samples the strobe, and the following words come in the next consecutive cycles.
- R6: word_vld_o is high for exactly 120/WORD_W consecutive cycles per strobe. If no new strobe comes, it then falls low and the word output returns to all zeros.
- R7: frame_vld_o is high only together with word 0 of a frame, one cycle after a strobe.
- R8: A strobe that arrives while a burst is still running cuts that burst off. Word 0 of the new frame follows in the next cycle. The words already sent are an exact prefix of the cut-off frame.
- R9: The fields are sampled only at the strobe. Changing them during a burst does not alter the words of that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transceiver user clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_stb | input | 1 | One-cycle pulse that loads a new frame |
| hdr_valid | input | 1 | Selects the data header code (1) or the idle header code (0) |
| ictl_i | input | 2 | Internal control field |
| data_i | input | 80 | Main payload field |
| ectl_i | input | 2 | External control field |
| fec_i | input | 32 | Check word, used when WIDE_BUS is 0 |
| extra_i | input | 32 | Extra payload, used when WIDE_BUS is 1 |
| word_o | output | WORD_W | Outgoing word, most significant frame bits first |
| word_vld_o | output | 1 | High on every emitted word |
| frame_vld_o | output | 1 | High on word 0 of each frame |

## Verification
The hardest condition to reach from the ports is a strobe that lands in the middle of a burst. It does not occur when the strobe keeps to its normal period. The stimulus therefore shortens the strobe spacing on purpose to three and then two cycles. This cuts off the 20-bit instance part-way through a frame, while the 40-bit instance finishes exactly or is also cut off. The scoreboard then checks that the partial words form a prefix of the cut-off frame. The field inputs are scrambled right after every strobe, so any leak of live inputs into a running burst shows up as a mismatch when the frame is rebuilt.

// File: rtl/gbx_pkg.sv
package gbx_pkg;

    localparam int FRAME_W = 120;
    localparam int HDR_W   = 4;
    localparam int ICTL_W  = 2;
    localparam int DATA_W  = 80;
    localparam int ECTL_W  = 2;
    localparam int TAIL_W  = 32;

    // Field order from the most significant end is the wire order.
    typedef struct packed {
        logic [HDR_W-1:0]  hdr;
        logic [ICTL_W-1:0] ictl;
        logic [DATA_W-1:0] data;
        logic [ECTL_W-1:0] ectl;
        logic [TAIL_W-1:0] tail;
    } gbx_frame_t;

endpackage

// File: rtl/gbx_frame_assembler.sv
module gbx_frame_assembler
    import gbx_pkg::*;
#(
    parameter bit         WIDE_BUS = 1'b0,
    parameter logic [3:0] HDR_DATA = 4'h5,
    parameter logic [3:0] HDR_IDLE = 4'h6
) (
    input  logic              hdr_valid,
    input  logic [ICTL_W-1:0] ictl,
    input  logic [DATA_W-1:0] data,
    input  logic [ECTL_W-1:0] ectl,
    input  logic [TAIL_W-1:0] fec,
    input  logic [TAIL_W-1:0] extra,
    output gbx_frame_t        frame
);

    always_comb begin
        frame.hdr  = hdr_valid ? HDR_DATA : HDR_IDLE;
        frame.ictl = ictl;
        frame.data = data;
        frame.ectl = ectl;
        // Wide payload mode reuses the check slot for user bits.
        frame.tail = WIDE_BUS ? extra : fec;
    end

endmodule

// File: rtl/gbx_frame_hold.sv
module gbx_frame_hold
    import gbx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  gbx_frame_t frame_in,
    output gbx_frame_t frame_out
);

    typedef struct packed {
        gbx_frame_t frm;
    } hold_t;

    hold_t hold_d, hold_q;

    always_comb begin
        hold_d = hold_q;
        if (load) begin
            hold_d.frm = frame_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
        end else begin
            hold_q <= hold_d;
        end
    end

    assign frame_out = hold_q.frm;

endmodule

// File: rtl/gbx_word_sequencer.sv
module gbx_word_sequencer #(
    parameter int N_WORDS = 6,
    localparam int CNT_W  = (N_WORDS > 1) ? $clog2(N_WORDS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    output logic [CNT_W-1:0] nxt_idx,
    output logic             nxt_vld
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(N_WORDS - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             act;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d   = seq_q;
        nxt_vld = seq_q.act && (seq_q.cnt != LAST);
        nxt_idx = seq_q.cnt + 1'b1;
        if (start) begin
            seq_d.cnt = '0;
            seq_d.act = 1'b1;
        end else if (nxt_vld) begin
            seq_d.cnt = nxt_idx;
        end else begin
            seq_d.act = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

endmodule

// File: rtl/gbx_word_slicer.sv
module gbx_word_slicer
    import gbx_pkg::*;
#(
    parameter int WORD_W   = 20,
    localparam int N_WORDS = FRAME_W / WORD_W,
    localparam int CNT_W   = (N_WORDS > 1) ? $clog2(N_WORDS) : 1
) (
    input  gbx_frame_t        frame,
    input  logic [CNT_W-1:0]  idx,
    output logic [WORD_W-1:0] word
);

    logic [FRAME_W-1:0]             flat;
    logic [N_WORDS-1:0][WORD_W-1:0] words;

    assign flat = frame;

    for (genvar k = 0; k < N_WORDS; k++) begin : g_slice
        assign words[k] = flat[FRAME_W-1-k*WORD_W -: WORD_W];
    end

    always_comb begin
        word = '0;
        if (32'(idx) < N_WORDS) begin
            word = words[idx];
        end
    end

endmodule

// File: rtl/link_tx_gearbox.sv
module link_tx_gearbox
    import gbx_pkg::*;
#(
    parameter int         WORD_W   = 20,
    parameter bit         WIDE_BUS = 1'b0,
    parameter logic [3:0] HDR_DATA = 4'h5,
    parameter logic [3:0] HDR_IDLE = 4'h6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_stb,
    input  logic              hdr_valid,
    input  logic [1:0]        ictl_i,
    input  logic [79:0]       data_i,
    input  logic [1:0]        ectl_i,
    input  logic [31:0]       fec_i,
    input  logic [31:0]       extra_i,
    output logic [WORD_W-1:0] word_o,
    output logic              word_vld_o,
    output logic              frame_vld_o
);

    localparam int N_WORDS = FRAME_W / WORD_W;
    localparam int CNT_W   = (N_WORDS > 1) ? $clog2(N_WORDS) : 1;

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic              wvld;
        logic              fvld;
    } out_t;

    gbx_frame_t        asm_frame;
    gbx_frame_t        hold_frame;
    logic [CNT_W-1:0]  nxt_idx;
    logic              nxt_vld;
    logic [WORD_W-1:0] first_word;
    logic [WORD_W-1:0] next_word;
    out_t              out_d, out_q;

    gbx_frame_assembler #(
        .WIDE_BUS (WIDE_BUS),
        .HDR_DATA (HDR_DATA),
        .HDR_IDLE (HDR_IDLE)
    ) u_asm (
        .hdr_valid (hdr_valid),
        .ictl      (ictl_i),
        .data      (data_i),
        .ectl      (ectl_i),
        .fec       (fec_i),
        .extra     (extra_i),
        .frame     (asm_frame)
    );

    gbx_frame_hold u_hold (
        .clk       (clk),
        .rst       (rst),
        .load      (frame_stb),
        .frame_in  (asm_frame),
        .frame_out (hold_frame)
    );

    gbx_word_sequencer #(
        .N_WORDS (N_WORDS)
    ) u_seq (
        .clk     (clk),
        .rst     (rst),
        .start   (frame_stb),
        .nxt_idx (nxt_idx),
        .nxt_vld (nxt_vld)
    );

    // Word 0 bypasses the hold register so it leaves on the strobe edge.
    gbx_word_slicer #(
        .WORD_W (WORD_W)
    ) u_slice_first (
        .frame (asm_frame),
        .idx   ('0),
        .word  (first_word)
    );

    gbx_word_slicer #(
        .WORD_W (WORD_W)
    ) u_slice_next (
        .frame (hold_frame),
        .idx   (nxt_idx),
        .word  (next_word)
    );

    always_comb begin
        out_d = '0;
        if (frame_stb) begin
            out_d.word = first_word;
            out_d.wvld = 1'b1;
            out_d.fvld = 1'b1;
        end else if (nxt_vld) begin
            out_d.word = next_word;
            out_d.wvld = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign word_o      = out_q.word;
    assign word_vld_o  = out_q.wvld;
    assign frame_vld_o = out_q.fvld;

endmodule

// File: rtl/link_tx_gearbox_chk.sv
module link_tx_gearbox_chk #(
    parameter int         WORD_W   = 20,
    parameter logic [3:0] HDR_DATA = 4'h5,
    parameter logic [3:0] HDR_IDLE = 4'h6
) (
    input logic              clk,
    input logic              rst,
    input logic              frame_stb,
    input logic [WORD_W-1:0] word_o,
    input logic              word_vld_o,
    input logic              frame_vld_o
);

    localparam int N_WORDS = 120 / WORD_W;

    int unsigned wcnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            wcnt_q <= 0;
        end else if (frame_vld_o) begin
            wcnt_q <= 1;
        end else if (word_vld_o) begin
            wcnt_q <= wcnt_q + 1;
        end
    end

    p_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        (!frame_stb && !word_vld_o) |=> !word_vld_o);

    p_idle_zero_r6: assert property (@(posedge clk) disable iff (rst)
        !word_vld_o |-> (word_o == '0));

    p_start_r5: assert property (@(posedge clk) disable iff (rst)
        frame_stb |=> (frame_vld_o && word_vld_o));

    p_fvld_word_r7: assert property (@(posedge clk) disable iff (rst)
        frame_vld_o |-> word_vld_o);

    p_fvld_after_stb_r7: assert property (@(posedge clk) disable iff (rst)
        frame_vld_o |-> $past(frame_stb));

    p_hdr_code_r3: assert property (@(posedge clk) disable iff (rst)
        frame_vld_o |-> (word_o[WORD_W-1 -: 4] == HDR_DATA ||
                         word_o[WORD_W-1 -: 4] == HDR_IDLE));

    p_no_overrun_r6: assert property (@(posedge clk) disable iff (rst)
        (word_vld_o && !frame_vld_o) |-> (wcnt_q != 0 && wcnt_q < N_WORDS));

    p_contiguous_r6: assert property (@(posedge clk) disable iff (rst)
        (word_vld_o && !frame_vld_o) |-> $past(word_vld_o));

endmodule

bind link_tx_gearbox link_tx_gearbox_chk #(
    .WORD_W   (WORD_W),
    .HDR_DATA (HDR_DATA),
    .HDR_IDLE (HDR_IDLE)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .frame_stb   (frame_stb),
    .word_o      (word_o),
    .word_vld_o  (word_vld_o),
    .frame_vld_o (frame_vld_o)
);

// File: tb/link_tx_gearbox_bench.sv
module link_tx_gearbox_bench;

    localparam int         CLK_PERIOD = 10;
    localparam int         W_A = 20;
    localparam int         W_B = 40;
    localparam int         N_A = 120 / W_A;
    localparam int         N_B = 120 / W_B;
    localparam logic [3:0] HD  = 4'h5;
    localparam logic [3:0] HI  = 4'h6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        stb = 1'b0;
    logic        hv = 1'b0;
    logic [1:0]  ic = '0;
    logic [79:0] dt = '0;
    logic [1:0]  ec = '0;
    logic [31:0] fc = '0;
    logic [31:0] xt = '0;

    logic [W_A-1:0] wa;
    logic           wva, fva;
    logic [W_B-1:0] wb;
    logic           wvb, fvb;

    int n_total = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [119:0] qa[$];
    logic [119:0] qb[$];
    logic [119:0] acca = '0, accb = '0;
    int cnta = 0, cntb = 0;
    int ab_a = 0, ab_b = 0, exp_ab_a = 0, exp_ab_b = 0;
    int prev_gap = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    link_tx_gearbox #(.WORD_W(W_A), .WIDE_BUS(1'b0), .HDR_DATA(HD), .HDR_IDLE(HI)) u_link_tx_gearbox (
        .clk(clk), .rst(rst), .frame_stb(stb), .hdr_valid(hv), .ictl_i(ic), .data_i(dt),
        .ectl_i(ec), .fec_i(fc), .extra_i(xt), .word_o(wa), .word_vld_o(wva), .frame_vld_o(fva));

    link_tx_gearbox #(.WORD_W(W_B), .WIDE_BUS(1'b1), .HDR_DATA(HD), .HDR_IDLE(HI)) u_link_tx_gearbox_w40 (
        .clk(clk), .rst(rst), .frame_stb(stb), .hdr_valid(hv), .ictl_i(ic), .data_i(dt),
        .ectl_i(ec), .fec_i(fc), .extra_i(xt), .word_o(wb), .word_vld_o(wvb), .frame_vld_o(fvb));

    task automatic chk(input bit ok, input string what, input logic [119:0] act, input logic [119:0] exp);
        n_total++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", what, act, exp);
        end
    endtask

    function automatic logic [119:0] mk(input bit wide);
        return {hv ? HD : HI, ic, dt, ec, wide ? xt : fc};
    endfunction

    task automatic full_cmp(input string tag, input logic [119:0] act, input logic [119:0] exp);
        if (act[119:116] != exp[119:116])   chk(1'b0, {tag, " R3 header code"}, act, exp);
        else if (act[31:0] != exp[31:0])    chk(1'b0, {tag, " R4 tail field"}, act, exp);
        else                                chk(act == exp, {tag, " R2 R9 frame rebuild"}, act, exp);
    endtask

    task automatic scramble();
        hv = 1'($urandom);
        ic = 2'($urandom);
        dt = 80'({$urandom(), $urandom(), $urandom()});
        ec = 2'($urandom);
        fc = $urandom();
        xt = $urandom();
    endtask

    // Driver: called at posedge+1; strobe is captured at the next edge.
    task automatic send_frame(input int gap, input int pat, input bit hdr);
        logic [119:0] ea, eb;
        if (prev_gap != 0 && prev_gap < N_A) exp_ab_a++;
        if (prev_gap != 0 && prev_gap < N_B) exp_ab_b++;
        prev_gap = gap;
        scramble();
        hv = hdr;
        if (pat == 1) begin ic = '1; dt = '1; ec = '1; fc = '1; xt = '1; end
        if (pat == 2) begin ic = '0; dt = '0; ec = '0; fc = '0; xt = '0; end
        if (pat == 3) begin dt = {20{4'hA}}; fc = 32'h0F0F_1234; xt = 32'hC3C3_5A5A; end
        stb = 1'b1;
        ea = mk(1'b0);
        eb = mk(1'b1);
        qa.push_back(ea);
        qb.push_back(eb);
        @(posedge clk);
        #1;
        stb = 1'b0;
        scramble();  // R9: live inputs change during the burst
        @(negedge clk);
        chk(fva && wva && fvb && wvb, "R5 R7 word 0 one cycle after strobe",
            120'({fva, wva, fvb, wvb}), 120'hF);
        chk(wa == ea[119 -: W_A], "R5 first 20-bit word", 120'(wa), 120'(ea[119 -: W_A]));
        chk(wb == eb[119 -: W_B], "R5 first 40-bit word", 120'(wb), 120'(eb[119 -: W_B]));
        repeat (gap - 1) @(posedge clk);
        #1;
    endtask

    // Monitor for the 20-bit frame-mode instance
    always @(negedge clk) begin
        logic [119:0] e;
        if (!rst && !done) begin
            if (!wva) begin
                chk(wa == '0, "R6 idle word zero (20)", 120'(wa), '0);
                if (cnta != 0 && cnta != N_A) begin
                    chk(1'b0, "R6 burst cut short (20)", 120'(cnta), 120'(N_A));
                    cnta = 0;
                end
            end else begin
                if (fva) begin
                    if (cnta != 0 && cnta != N_A) begin
                        if (qa.size() == 0) chk(1'b0, "R8 no pending frame (20)", '0, 120'd1);
                        else begin
                            e = qa.pop_front();
                            chk(acca == (e >> (120 - cnta*W_A)), "R8 partial prefix (20)",
                                acca, e >> (120 - cnta*W_A));
                        end
                        ab_a++;
                    end
                    acca = '0;
                    cnta = 0;
                end else if (cnta == 0 || cnta == N_A) begin
                    chk(1'b0, "R7 word without frame start (20)", 120'(cnta), '0);
                end
                acca = {acca[119-W_A:0], wa};
                cnta++;
                if (cnta == N_A) begin
                    if (qa.size() == 0) chk(1'b0, "R5 unexpected frame (20)", acca, '0);
                    else full_cmp("w20", acca, qa.pop_front());
                end
            end
        end
    end

    // Monitor for the 40-bit wide-payload instance
    always @(negedge clk) begin
        logic [119:0] e;
        if (!rst && !done) begin
            if (!wvb) begin
                chk(wb == '0, "R6 idle word zero (40)", 120'(wb), '0);
                if (cntb != 0 && cntb != N_B) begin
                    chk(1'b0, "R6 burst cut short (40)", 120'(cntb), 120'(N_B));
                    cntb = 0;
                end
            end else begin
                if (fvb) begin
                    if (cntb != 0 && cntb != N_B) begin
                        if (qb.size() == 0) chk(1'b0, "R8 no pending frame (40)", '0, 120'd1);
                        else begin
                            e = qb.pop_front();
                            chk(accb == (e >> (120 - cntb*W_B)), "R8 partial prefix (40)",
                                accb, e >> (120 - cntb*W_B));
                        end
                        ab_b++;
                    end
                    accb = '0;
                    cntb = 0;
                end else if (cntb == 0 || cntb == N_B) begin
                    chk(1'b0, "R7 word without frame start (40)", 120'(cntb), '0);
                end
                accb = {accb[119-W_B:0], wb};
                cntb++;
                if (cntb == N_B) begin
                    if (qb.size() == 0) chk(1'b0, "R5 unexpected frame (40)", accb, '0);
                    else full_cmp("w40", accb, qb.pop_front());
                end
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        scramble();
        // R1: quiet after reset until the first strobe
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(!wva && !fva && wa == '0, "R1 reset state (20)", 120'({wva, fva, wa}), '0);
            chk(!wvb && !fvb && wb == '0, "R1 reset state (40)", 120'({wvb, fvb, wb}), '0);
        end
        @(posedge clk);
        #1;
        // Back-to-back frames at the nominal period, both header codes
        for (int i = 0; i < 8; i++) send_frame(N_A, 0, i[0]);
        send_frame(N_A, 1, 1'b1);
        send_frame(N_A, 2, 1'b0);
        send_frame(N_A, 3, 1'b1);
        // Idle gaps between frames
        for (int i = 0; i < 3; i++) send_frame(N_A + 3, 0, 1'b1);
        // R8: early strobes cut running bursts
        send_frame(3, 0, 1'b1);
        send_frame(2, 3, 1'b0);
        send_frame(N_A, 0, 1'b1);
        send_frame(N_A + 4, 1, 1'b0);
        repeat (12) @(posedge clk);
        @(negedge clk);
        chk(qa.size() == 0 && qb.size() == 0, "R5 every frame delivered",
            120'(qa.size() + qb.size()), '0);
        chk(ab_a == exp_ab_a, "R8 cut-off count (20)", 120'(ab_a), 120'(exp_ab_a));
        chk(ab_b == exp_ab_b, "R8 cut-off count (40)", 120'(ab_b), 120'(exp_ab_b));
        done = 1'b1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_total++;
            n_fail++;
            $display("FAIL watchdog expired act=%0d exp=0", 1);
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

endmodule